// File: doc/BRIEF.md
# RMII receive frame synchronizer

This block sits directly on the 50 MHz reference clock of a reduced media-independent interface (RMII) PHY at 100 Mbit/s. It captures the two receive data bits and the carrier/data-valid line on every rising edge. When carrier appears, it looks for the frame delimiter inside a fixed window. It then packs the payload dibits into bytes, least significant bit first. Each byte leaves as a one-cycle beat that carries start, end and error flags and a running byte index.

Any frame end, abort or rejected attempt puts the block into a gap-wait state. It leaves that state only after the carrier line has stayed low for a programmable number of consecutive samples. A single high sample restarts the count. This keeps the carrier line's end-of-frame toggling and line noise from being taken as a new frame. Receive-error handling can be switched on or off, so a board that does not wire the error pin can rely on a downstream CRC check instead.

Top module: `rmii_rx_sync`

## Requirements
- R1: Reset clears every output. Reset leaves the block in gap-wait, so the first frame is accepted only after `cfg_gap_cycles` consecutive low carrier samples. A frame that starts sooner yields no beats.
- R2: Within a dibit, `rxd[0]` is the earlier bit. Four dibits make a byte, with the first dibit in bits [1:0]. Each byte produces one cycle of `out_valid`. The first beat of a frame has `out_sof`, and `out_count` gives the 1-based byte index.
- R3: After carrier rises, any number of `00` dibits may come first, then one or more preamble dibits `01`, then the delimiter's final dibit `11`. Byte 0 starts with the next dibit. Payload bytes that equal 0xD5 are passed through as data.
- R4: The delimiter must be among the first `SFD_LIMIT` (default 48) carrier-high samples, counting the rising sample. If it is not, the attempt is dropped with no beats and the block enters gap-wait.
- R5: If carrier goes low before the delimiter, the attempt is dropped with no beats and the block enters gap-wait.
- R6: With `cfg_use_rxer`=1, a high `rx_er` during the payload ends the frame. The block emits one beat with `out_err` and `out_eof` set, carrying the last complete byte, and its count equals the number of complete bytes.
- R7: With `cfg_use_rxer`=0, `rx_er` has no effect on any output.
- R8: The frame ends when carrier is low on both dibits of an aligned pair (byte positions 0–1 or 2–3). The last complete byte is then emitted with `out_eof` and the total count, and a partial byte is discarded. Low samples outside an aligned pair, including alternate-cycle toggling, do not end the frame.
- R9: In gap-wait, the block re-arms after `cfg_gap_cycles` consecutive low samples, and any high sample restarts the count. A frame whose carrier rises earlier is dropped whole. The bench uses both 48 and 18 as gap values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz RMII reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 2 | Receive dibit, bit 0 earlier |
| crs_dv | input | 1 | Carrier sense / data valid |
| rx_er | input | 1 | Receive error from the PHY |
| cfg_use_rxer | input | 1 | 1 = honour `rx_er` |
| cfg_gap_cycles | input | GAP_W | Minimum quiet samples before re-arming |
| out_valid | output | 1 | Byte beat strobe |
| out_data | output | 8 | Received byte |
| out_sof | output | 1 | First beat of a frame |
| out_eof | output | 1 | Last beat of a frame |
| out_err | output | 1 | Frame aborted on receive error |
| out_count | output | CNT_W | 1-based byte index; total on the end beat |

## Verification
The bench probes the exact edges of both windows.

- **Delimiter window:** it places the delimiter on the 48th carrier sample and then on the 49th. An off-by-one search window would accept the second frame or lose the first.
- **Gap length:** it offers gaps of exactly the programmed length and one sample short, including after aborts, where the frame's own closing low pair already counts toward the gap. It also offers a lone high sample inside the gap. A counter that does not restart, or that counts the wrong samples, lets a too-early frame through.
- **End detection:** alternate-cycle carrier toggling and a misaligned low pair run over live payload, and a trailing half byte sits before the end. A careless end detector would truncate the frame or emit a garbage final byte.
- **Error pin:** the same error stimulus is replayed with error handling off, to show the pin really is ignored.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

    typedef enum logic [1:0] {
        ST_GAP  = 2'd0,
        ST_IDLE = 2'd1,
        ST_HUNT = 2'd2,
        ST_DATA = 2'd3
    } rx_state_e;

    localparam logic [1:0] DIBIT_PRE = 2'b01;
    localparam logic [1:0] DIBIT_SFD = 2'b11;

endpackage

// File: rtl/rmii_rx_capture.sv
module rmii_rx_capture (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rxd,
    input  logic       crs_dv,
    input  logic       rx_er,
    output logic [1:0] s_rxd,
    output logic       s_crs,
    output logic       s_er
);
    typedef struct packed {
        logic [1:0] rxd;
        logic       crs;
        logic       er;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d.rxd = rxd;
        cap_d.crs = crs_dv;
        cap_d.er  = rx_er;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign s_rxd = cap_q.rxd;
    assign s_crs = cap_q.crs;
    assign s_er  = cap_q.er;
endmodule

// File: rtl/rmii_gap_guard.sv
module rmii_gap_guard #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             crs,
    input  logic [GAP_W-1:0] limit,
    output logic             quiet
);
    logic [GAP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!active || crs)        cnt_d = '0;
        else if (cnt_q != '1)      cnt_d = cnt_q + 1'b1;
        quiet = active && !crs &&
                (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rmii_rx_sync.sv
module rmii_rx_sync
    import rmii_rx_pkg::*;
#(
    parameter int SFD_LIMIT = 48,
    parameter int GAP_W     = 8,
    parameter int CNT_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rxd,
    input  logic             crs_dv,
    input  logic             rx_er,
    input  logic             cfg_use_rxer,
    input  logic [GAP_W-1:0] cfg_gap_cycles,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic             out_err,
    output logic [CNT_W-1:0] out_count
);
    localparam int HUNT_W = $clog2(SFD_LIMIT + 1);
    localparam logic [HUNT_W-1:0] HUNT_LAST = HUNT_W'(SFD_LIMIT - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [HUNT_W-1:0] hunt;
        logic              seen_pre;
        logic [1:0]        idx;
        logic              low_first;
        logic [7:0]        shreg;
        logic [7:0]        held;
        logic              have_held;
        logic [CNT_W-1:0]  nbytes;
        logic              o_valid;
        logic [7:0]        o_data;
        logic              o_sof;
        logic              o_eof;
        logic              o_err;
        logic [CNT_W-1:0]  o_cnt;
    } ctx_t;

    ctx_t r_d, r_q;

    logic [1:0] s_rxd;
    logic       s_crs, s_er, gap_quiet, er_hit;
    logic [7:0] byte_now;

    rmii_rx_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .rxd    (rxd),
        .crs_dv (crs_dv),
        .rx_er  (rx_er),
        .s_rxd  (s_rxd),
        .s_crs  (s_crs),
        .s_er   (s_er)
    );

    rmii_gap_guard #(.GAP_W(GAP_W)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (r_q.st == ST_GAP),
        .crs    (s_crs),
        .limit  (cfg_gap_cycles),
        .quiet  (gap_quiet)
    );

    always_comb begin
        r_d         = r_q;
        r_d.o_valid = 1'b0;
        r_d.o_sof   = 1'b0;
        r_d.o_eof   = 1'b0;
        r_d.o_err   = 1'b0;
        er_hit      = cfg_use_rxer && s_er;
        byte_now    = {s_rxd, r_q.shreg[7:2]};

        case (r_q.st)
            ST_GAP: begin
                if (gap_quiet) r_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (s_crs) begin
                    r_d.st       = ST_HUNT;
                    r_d.hunt     = HUNT_W'(1);
                    r_d.seen_pre = (s_rxd == DIBIT_PRE);
                end
            end
            ST_HUNT: begin
                if (!s_crs || er_hit) begin
                    r_d.st = ST_GAP;
                end else if (s_rxd == DIBIT_SFD && r_q.seen_pre) begin
                    r_d.st        = ST_DATA;
                    r_d.idx       = 2'd0;
                    r_d.low_first = 1'b0;
                    r_d.have_held = 1'b0;
                    r_d.nbytes    = '0;
                end else if (r_q.hunt >= HUNT_LAST) begin
                    r_d.st = ST_GAP;
                end else begin
                    r_d.hunt     = r_q.hunt + 1'b1;
                    r_d.seen_pre = (s_rxd == DIBIT_PRE);
                end
            end
            ST_DATA: begin
                if (er_hit) begin
                    r_d.st      = ST_GAP;
                    r_d.o_valid = 1'b1;
                    r_d.o_err   = 1'b1;
                    r_d.o_eof   = 1'b1;
                    r_d.o_data  = r_q.held;
                    r_d.o_sof   = (r_q.nbytes == '0);
                    r_d.o_cnt   = r_q.nbytes + CNT_W'(r_q.have_held);
                end else if (r_q.idx[0] && !s_crs && r_q.low_first) begin
                    r_d.st = ST_GAP;
                    if (r_q.have_held) begin
                        r_d.o_valid = 1'b1;
                        r_d.o_eof   = 1'b1;
                        r_d.o_data  = r_q.held;
                        r_d.o_sof   = (r_q.nbytes == '0);
                        r_d.o_cnt   = r_q.nbytes + 1'b1;
                    end
                end else begin
                    r_d.shreg = byte_now;
                    r_d.idx   = r_q.idx + 1'b1;
                    if (!r_q.idx[0]) r_d.low_first = !s_crs;
                    if (r_q.idx == 2'd3) begin
                        if (r_q.have_held) begin
                            r_d.o_valid = 1'b1;
                            r_d.o_data  = r_q.held;
                            r_d.o_sof   = (r_q.nbytes == '0);
                            r_d.o_cnt   = r_q.nbytes + 1'b1;
                            r_d.nbytes  = r_q.nbytes + 1'b1;
                        end
                        r_d.held      = byte_now;
                        r_d.have_held = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_GAP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_valid = r_q.o_valid;
    assign out_data  = r_q.o_data;
    assign out_sof   = r_q.o_sof;
    assign out_eof   = r_q.o_eof;
    assign out_err   = r_q.o_err;
    assign out_count = r_q.o_cnt;
endmodule

// File: rtl/rmii_rx_sync_chk.sv
module rmii_rx_sync_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             crs_dv,
    input logic             rx_er,
    input logic             cfg_use_rxer,
    input logic             out_valid,
    input logic             out_sof,
    input logic             out_eof,
    input logic             out_err,
    input logic [CNT_W-1:0] out_count
);
    AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eof || out_err) |-> out_valid); // R2

    AST_SOF_IS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof && !out_err) |-> (out_count == CNT_W'(1))); // R2

    AST_ERR_CLOSES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_eof); // R6

    AST_ERR_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> ($past(rx_er, 2) && $past(cfg_use_rxer, 1))); // R7

    AST_EOF_ON_LOW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eof && !out_err) |-> (!$past(crs_dv, 2) && !$past(crs_dv, 3))); // R8
endmodule

bind rmii_rx_sync rmii_rx_sync_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/rmii_rx_sync_test.sv
module rmii_rx_sync_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  rxd;
    logic        crs_dv, rx_er, cfg_use_rxer;
    logic [7:0]  cfg_gap_cycles;
    logic        out_valid, out_sof, out_eof, out_err;
    logic [7:0]  out_data;
    logic [11:0] out_count;

    always #5 clk = ~clk;

    rmii_rx_sync uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .crs_dv(crs_dv), .rx_er(rx_er),
        .cfg_use_rxer(cfg_use_rxer), .cfg_gap_cycles(cfg_gap_cycles),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .out_err(out_err), .out_count(out_count)
    );

    int checks = 0;
    int fails  = 0;
    int cap_n  = 0;
    logic [7:0] cap_data [64];
    logic       cap_sof  [64];
    logic       cap_eof  [64];
    logic       cap_err  [64];
    int         cap_cnt  [64];

    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 64) begin
            cap_data[cap_n] = out_data;
            cap_sof[cap_n]  = out_sof;
            cap_eof[cap_n]  = out_eof;
            cap_err[cap_n]  = out_err;
            cap_cnt[cap_n]  = int'(out_count);
            cap_n = cap_n + 1;
        end
    end

    // gap, zeros, preamble, bytes, first, mode, extra, err_byte, use_er
    localparam int NV = 10;
    localparam int VEC [NV][9] = '{
        '{30, 3, 20, 6, 8'h10, 0, 0, 255, 1},
        '{18, 0, 47, 4, 8'h20, 0, 0, 255, 1},
        '{20, 0, 48, 4, 8'h30, 0, 0, 255, 1},
        '{16, 5, 10, 5, 8'hD3, 1, 0, 255, 1},
        '{17, 2, 12, 3, 8'h40, 0, 0, 255, 1},
        '{15, 2, 12, 3, 8'h44, 0, 0, 255, 1},
        '{16, 1, 14, 5, 8'h50, 2, 2, 255, 1},
        '{18, 0, 20, 6, 8'h60, 0, 0, 3,   1},
        '{20, 0, 20, 6, 8'h70, 0, 0, 3,   0},
        '{18, 4, 31, 1, 8'hA5, 0, 0, 255, 1}
    };
    string tags [NV] = '{"R2 R3", "R4 R9", "R4", "R8 R9 R3", "R9", "R9",
                         "R8", "R6", "R7", "R2 R3"};

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put(input logic c, input logic [1:0] d, input logic e);
        crs_dv = c; rxd = d; rx_er = e;
        @(negedge clk);
    endtask

    task automatic lows(input int n);
        for (int i = 0; i < n; i++) put(1'b0, 2'b00, 1'b0);
    endtask

    // mode: 0 plain, 1 toggle carrier on last two bytes, 2 misaligned lows, 3 carrier drop in hunt
    task automatic send_frame(input int nz, input int np, input int nb, input int first,
                              input int mode, input int extra, input int errb);
        logic [7:0] by;
        logic       c;
        for (int i = 0; i < nz; i++) put(1'b1, 2'b00, 1'b0);
        for (int i = 0; i < np; i++) begin
            put(1'b1, 2'b01, 1'b0);
            if (mode == 3 && i == 4) put(1'b0, 2'b01, 1'b0);
        end
        put(1'b1, 2'b11, 1'b0);
        for (int b = 0; b < nb; b++) begin
            by = 8'(first + b);
            for (int k = 0; k < 4; k++) begin
                c = 1'b1;
                if (mode == 1 && b >= nb - 2) c = (k % 2 == 1);
                if (mode == 2 && b == 1 && (k == 1 || k == 2)) c = 1'b0;
                put(c, by[2*k +: 2], (b == errb && k == 1));
            end
        end
        for (int i = 0; i < extra; i++) put(1'b1, 2'b10, 1'b0);
        put(1'b0, 2'b00, 1'b0);
        put(1'b0, 2'b00, 1'b0);
    endtask

    task automatic check_frame(input string req, input bit acc, input int nb,
                               input int first, input int errb, input int use_er);
        int  expn;
        bit  last, ok;
        expn = !acc ? 0 : ((use_er != 0 && errb < nb) ? errb : nb);
        chk(cap_n == expn, req, "beat count", cap_n, expn);
        for (int i = 0; i < expn && i < cap_n; i++) begin
            last = (i == expn - 1);
            ok = (cap_data[i] == 8'(first + i)) && (cap_sof[i] == (i == 0)) &&
                 (cap_eof[i] == last) &&
                 (cap_err[i] == (last && use_er != 0 && errb < nb)) &&
                 (cap_cnt[i] == i + 1);
            chk(ok, req, "beat data/flags/count",
                {cap_data[i], 4'(cap_cnt[i]), cap_sof[i], cap_eof[i], cap_err[i]},
                {8'(first + i), 4'(i + 1), 1'(i == 0), last,
                 1'(last && use_er != 0 && errb < nb)});
        end
        cap_n = 0;
    endtask

    task automatic check_reset_outputs();
        chk(!out_valid && !out_sof && !out_eof && !out_err && out_count == 0 &&
            out_data == 0, "R1", "outputs in reset",
            {out_valid, out_sof, out_eof, out_err}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int limit;
        bit in_gap, acc;
        rst_n = 1'b0; rxd = 2'b00; crs_dv = 1'b0; rx_er = 1'b0;
        cfg_use_rxer = 1'b1; cfg_gap_cycles = 8'd18;
        @(negedge clk);
        repeat (3) @(negedge clk);
        check_reset_outputs();
        rst_n = 1'b1;
        limit = 18;
        in_gap = 1'b1;

        lows(VEC[0][0]);
        for (int v = 0; v < NV; v++) begin
            cfg_use_rxer = VEC[v][8][0];
            cap_n = 0;
            acc = ((VEC[v][0] + (in_gap ? 2 : 0)) >= limit) &&
                  (VEC[v][1] + VEC[v][2] + 1 <= 48);
            send_frame(VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4],
                       VEC[v][5], VEC[v][6], VEC[v][7]);
            lows((v < NV - 1) ? VEC[v + 1][0] : 30);
            check_frame(tags[v], acc, VEC[v][3], VEC[v][4], VEC[v][7], VEC[v][8]);
            in_gap = !acc || (VEC[v][8] != 0 && VEC[v][7] < VEC[v][3]);
        end

        // R5: carrier drop during the delimiter search
        cfg_use_rxer = 1'b1;
        send_frame(1, 10, 4, 8'h80, 3, 0, 255);
        lows(20);
        check_frame("R5", 1'b0, 4, 8'h80, 255, 1);
        send_frame(2, 10, 3, 8'h90, 0, 0, 255);
        lows(10);
        check_frame("R5", 1'b1, 3, 8'h90, 255, 1);

        // R9: a single high sample restarts the quiet count
        put(1'b1, 2'b00, 1'b0);
        lows(17);
        send_frame(2, 10, 3, 8'hA0, 0, 0, 255);
        lows(18);
        check_frame("R9", 1'b0, 3, 8'hA0, 255, 1);

        // R9: default gap length of 48
        cfg_gap_cycles = 8'd48;
        lows(32);
        send_frame(2, 10, 2, 8'hB0, 0, 0, 255);
        lows(47);
        check_frame("R9", 1'b1, 2, 8'hB0, 255, 1);
        send_frame(2, 10, 2, 8'hC0, 0, 0, 255);
        lows(46);
        check_frame("R9", 1'b0, 2, 8'hC0, 255, 1);
        send_frame(2, 10, 2, 8'hD0, 0, 0, 255);
        lows(5);
        check_frame("R9", 1'b1, 2, 8'hD0, 255, 1);

        // R1: reset mid-run, then gap-wait applies before the first frame
        rst_n = 1'b0;
        lows(3);
        check_reset_outputs();
        rst_n = 1'b1;
        lows(3);
        send_frame(2, 10, 2, 8'hE0, 0, 0, 255);
        lows(60);
        check_frame("R1", 1'b0, 2, 8'hE0, 255, 1);
        send_frame(2, 10, 2, 8'hE8, 0, 0, 255);
        lows(5);
        check_frame("R1", 1'b1, 2, 8'hE8, 255, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule